// File: doc/BRIEF.md
# Sync Input Release Stretcher

This block cleans up an external synchronisation input. The raw pin is brought into the clock domain through a short flip-flop chain. A polarity bit then turns it into an "active" level. When the stored hold value is nonzero, the output becomes active as soon as the input does and stays active for a programmable number of prescaler ticks after the input goes inactive. Each new activation restarts the hold window. Short drop-outs of the input are therefore absorbed.

A hold value of zero turns the timer off, and the output follows the corrected input directly. A fixed prescaler of `2^PRESCALE_BITS` clocks sets the tick. The hold value is 8 bits wide and is loaded through a write strobe. The output is accompanied by a one-clock strobe on each new activation, for use by latch and interrupt logic downstream.

Top module: `sync_dropout_stretch`

## Requirements
- R1: While the stored hold value is 0, `sync_out` follows the polarity-corrected input, rising and falling at the 3rd rising clock edge after the pin changes.
- R2: With any hold value, `sync_out` rises at the 3rd rising clock edge after the pin enters its active level (two synchroniser stages plus the output register).
- R3: With a nonzero hold value D, `sync_out` falls exactly D×2^PRESCALE_BITS clocks after the last edge at which the synchronised input was active, which is the rising edge number 2 + D×2^PRESCALE_BITS after the pin leaves its active level.
- R4: An activation during a running hold keeps `sync_out` high without a gap, produces no new strobe, and restarts the full hold window from the later release.
- R5: With `pol_high` = 1 a high pin level is active; with `pol_high` = 0 a low pin level is active.
- R6: A nonzero hold value written while the hold is counting does not change that countdown; it applies from the next activation onward.
- R7: `act_pulse` is high for exactly one clock, in the first clock in which `sync_out` is high after being low, and at no other time.
- R8: Reset (synchronous, active-low `rst_n`) forces `sync_out` and `act_pulse` low, clears the hold value, the countdown and the prescaler, and the output stays low until the pin is seen active after reset.
- R9: One hold tick equals 2^PRESCALE_BITS clocks (16384 with the default of 14), and the full-scale hold value is 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 1 | Raw, asynchronous sync pin |
| pol_high | input | 1 | 1: high pin level is active; 0: low level is active |
| wr_en | input | 1 | Write strobe for the hold value |
| wr_data | input | CNT_W | Hold value in prescaler ticks; 0 turns the timer off |
| sync_out | output | 1 | Clean, stretched sync level, active high |
| act_pulse | output | 1 | One-clock strobe on each rise of `sync_out` |

## Verification
The bench builds the block with `PRESCALE_BITS` = 3, so one tick is 8 clocks. This puts every hold length within reach, up to the full-scale value of 255 (2040 clocks), and each release edge is counted to the exact clock. The default `CNT_W` and the two-stage synchroniser are kept, so the activation latency and the drop-out timing match the default build. Only the tick length is shortened, which exercises the prescaler wrap and retrigger restart many times per run.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  // Clocks of hold for a given tick count and prescaler width.
  function automatic int unsigned hold_clocks(input int unsigned ticks,
                                              input int unsigned pbits);
    return ticks << pbits;
  endfunction

  // Polarity correction: returns 1 when the level counts as active.
  function automatic logic is_active(input logic level, input logic pol_high);
    return pol_high ? level : ~level;
  endfunction

endpackage

// File: rtl/sdd_sync.sv
module sdd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_level,
  input  logic d,
  output logic q
);
  logic chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= rst_level;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= rst_level;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdd_prescaler.sv
module sdd_prescaler #(
  parameter int PBITS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  logic [PBITS-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) phase <= '0;
    else                 phase <= phase + 1'b1;
  end

  // Last phase of each period: one tick every 2^PBITS clocks after a clear.
  assign tick = &phase;
endmodule

// File: rtl/sdd_holdoff.sv
module sdd_holdoff #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             bypass,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             out,
  output logic             rise
);
  logic [CNT_W-1:0] cnt_next;
  logic             out_next;

  always_comb begin
    if (bypass)                   cnt_next = '0;
    else if (act)                 cnt_next = load_val;
    else if (tick && cnt != '0)   cnt_next = cnt - 1'b1;
    else                          cnt_next = cnt;
    out_next = act | (cnt_next != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      out  <= 1'b0;
      rise <= 1'b0;
    end else begin
      cnt  <= cnt_next;
      out  <= out_next;
      rise <= out_next & ~out;
    end
  end
endmodule

// File: rtl/sync_dropout_stretch.sv
module sync_dropout_stretch #(
  parameter int PRESCALE_BITS = 14,
  parameter int CNT_W         = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             pol_high,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic             sync_out,
  output logic             act_pulse
);
  // Named internal events, brought out for the bound checker.
  logic [CNT_W-1:0] delay_q;
  logic [CNT_W-1:0] hold_cnt;
  logic             pin_sync;
  logic             act_in;
  logic             bypass;
  logic             load_ev;
  logic             tick;

  always_ff @(posedge clk) begin
    if (!rst_n)     delay_q <= '0;
    else if (wr_en) delay_q <= wr_data;
  end

  sdd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_level (~pol_high),
    .d         (pin_in),
    .q         (pin_sync)
  );

  assign act_in  = sdd_pkg::is_active(pin_sync, pol_high);
  assign bypass  = (delay_q == '0);
  assign load_ev = act_in & ~bypass;

  sdd_prescaler #(.PBITS(PRESCALE_BITS)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (act_in | bypass),
    .tick  (tick)
  );

  sdd_holdoff #(.CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act_in),
    .bypass   (bypass),
    .tick     (tick),
    .load_val (delay_q),
    .cnt      (hold_cnt),
    .out      (sync_out),
    .rise     (act_pulse)
  );
endmodule

// File: rtl/sync_dropout_stretch_chk.sv
module sync_dropout_stretch_chk #(
  parameter int PRESCALE_BITS = 14,
  parameter int CNT_W         = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_out,
  input logic             act_pulse,
  input logic             bypass,
  input logic             load_ev,
  input logic             tick,
  input logic [CNT_W-1:0] delay_q,
  input logic [CNT_W-1:0] hold_cnt
);
  // Clocks since the last load, and the value captured at that load.
  logic [31:0]      since;
  logic [CNT_W-1:0] cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0;
      cap   <= '0;
    end else if (load_ev) begin
      since <= '0;
      cap   <= delay_q;
    end else if (since != 32'hFFFF_FFFF) begin
      since <= since + 1'b1;
    end
  end

  // R3: the release edge lands exactly hold_clocks after the last load
  a_r3_release_time: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_out) && !bypass && !$past(bypass))
      |-> (since == sdd_pkg::hold_clocks(cap, PRESCALE_BITS)));

  // R3: a live countdown always holds the output active
  a_r3_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |-> sync_out);

  // R9: the count moves down by one, and only on a tick, unless reloaded or cleared
  a_r9_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_ev) && hold_cnt != $past(hold_cnt) && hold_cnt != '0)
      |-> (hold_cnt == $past(hold_cnt) - 1'b1) && $past(tick));

  // R1: no countdown while the timer is off
  a_r1_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (hold_cnt == '0));

  // R7: strobe only in the first active cycle
  a_r7_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> (sync_out && !$past(sync_out)));

  // R7: every rise carries a strobe
  a_r7_rise_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> act_pulse);
endmodule

bind sync_dropout_stretch sync_dropout_stretch_chk #(
  .PRESCALE_BITS (PRESCALE_BITS),
  .CNT_W         (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_out  (sync_out),
  .act_pulse (act_pulse),
  .bypass    (bypass),
  .load_ev   (load_ev),
  .tick      (tick),
  .delay_q   (delay_q),
  .hold_cnt  (hold_cnt)
);

// File: tb/sync_dropout_stretch_test.sv
module sync_dropout_stretch_test;
  localparam int CLK_PERIOD = 10;
  localparam int PB         = 3;
  localparam int TICK       = 1 << PB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       pol_high = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sync_out, act_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_dropout_stretch #(.PRESCALE_BITS(PB), .CNT_W(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol_high(pol_high),
    .wr_en(wr_en), .wr_data(wr_data), .sync_out(sync_out), .act_pulse(act_pulse)
  );

  typedef struct packed {
    logic       pol;
    logic [7:0] dly;
    logic [7:0] len;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd0,   8'd4},
    '{1'b1, 8'd1,   8'd3},
    '{1'b1, 8'd3,   8'd5},
    '{1'b0, 8'd2,   8'd4},
    '{1'b0, 8'd0,   8'd6},
    '{1'b1, 8'd255, 8'd3},
    '{1'b0, 8'd7,   8'd8}
  };

  // Edge count after the pin release at which sync_out is first seen low.
  function automatic int exp_fall(input int d);
    return (d == 0) ? 3 : 2 + d * TICK;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_delay(input int d);
    wr_en = 1'b1;
    wr_data = 8'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic drive_active(input int len, output int rise_at, output int pulses);
    pin_in = pol_high;
    rise_at = 0;
    pulses = 0;
    for (int n = 1; n <= len; n++) begin
      step();
      if (sync_out && rise_at == 0) rise_at = n;
      if (act_pulse) pulses++;
    end
  endtask

  task automatic drive_release(output int fall_at, inout int pulses);
    pin_in = ~pol_high;
    fall_at = 0;
    for (int n = 1; n <= 4000; n++) begin
      step();
      if (act_pulse) pulses++;
      if (!sync_out) begin
        fall_at = n;
        break;
      end
    end
  endtask

  task automatic settle(input logic pol);
    write_delay(0);
    pol_high = pol;
    pin_in = ~pol;
    repeat (6) step();
  endtask

  initial begin
    int rise_at, pulses, fall_at;
    // R8: reset with the pin held active keeps the output low
    pol_high = 1'b1;
    pin_in = 1'b1;
    repeat (5) step();
    check(sync_out == 1'b0, "R8 out in reset", sync_out, 0);
    check(act_pulse == 1'b0, "R8 strobe in reset", act_pulse, 0);
    pin_in = 1'b0;
    step();
    rst_n = 1'b1;
    write_delay(5);
    repeat (10) step();
    check(sync_out == 1'b0, "R8 idle after reset", sync_out, 0);

    // Vector table: R1 R2 R3 R5 R7 R9
    for (int v = 0; v < NV; v++) begin
      settle(VECS[v].pol);
      write_delay(int'(VECS[v].dly));
      check(sync_out == 1'b0, "R5 idle at inactive level", sync_out, 0);
      drive_active(int'(VECS[v].len), rise_at, pulses);
      check(rise_at == 3, "R2 rise edge", rise_at, 3);
      drive_release(fall_at, pulses);
      check(fall_at == exp_fall(int'(VECS[v].dly)),
            (VECS[v].dly == 0) ? "R1 bypass fall edge" : "R3 R9 release edge",
            fall_at, exp_fall(int'(VECS[v].dly)));
      check(pulses == 1, "R7 one strobe per activation", pulses, 1);
    end

    // R4: retrigger during the hold window
    settle(1'b1);
    write_delay(2);
    drive_active(4, rise_at, pulses);
    pin_in = 1'b0;
    begin
      int low_seen = 0;
      for (int n = 1; n <= 10; n++) begin
        step();
        if (!sync_out) low_seen++;
      end
      check(low_seen == 0, "R4 held before retrigger", low_seen, 0);
      drive_active(4, rise_at, pulses);
      check(pulses == 0, "R4 no strobe on retrigger", pulses, 0);
      check(rise_at == 1, "R4 no gap on retrigger", rise_at, 1);
    end
    drive_release(fall_at, pulses);
    check(fall_at == exp_fall(2), "R4 window restarted", fall_at, exp_fall(2));

    // R6: new value written mid-countdown
    settle(1'b1);
    write_delay(4);
    drive_active(4, rise_at, pulses);
    pin_in = 1'b0;
    fall_at = 0;
    for (int n = 1; n <= 200; n++) begin
      if (n == 5) begin
        wr_en = 1'b1;
        wr_data = 8'd1;
      end
      step();
      wr_en = 1'b0;
      if (!sync_out) begin
        fall_at = n;
        break;
      end
    end
    check(fall_at == exp_fall(4), "R6 countdown unchanged", fall_at, exp_fall(4));
    drive_active(4, rise_at, pulses);
    drive_release(fall_at, pulses);
    check(fall_at == exp_fall(1), "R6 new value used", fall_at, exp_fall(1));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule